// File: doc/BRIEF.md
# Adaptive Packet Batch Dispatcher

This block sits between a host processor that produces packet descriptors and a pool of parallel cores that process them a warp at a time. The host pushes 32-bit descriptors into a circular task queue. The dispatcher watches two things: how many descriptors are waiting, and whether a core slot is free. From these it decides when to hand a batch to the cores. Each hand-off carries the queue slot of the first descriptor in the batch and the number of descriptors in it. The cores then fetch the descriptors through a read port.

Full batches go out as soon as enough descriptors are queued and a core is free. This keeps throughput high under bursts. A smaller batch is released when the oldest waiting work has sat for a programmable number of cycles. This bounds latency when traffic is sparse. The batch size adapts to traffic. It is counted in warps, starts at one warp, and moves between one warp and a maximum number of warps. It halves after a quiet measurement window and doubles after a busy one. Large batches cost delay, and small batches cost scheduling effort.

Top module: `warp_batch_dispatcher`

## Requirements
- R1: After reset the queue is empty, `push_ready` is 1, `issue_valid` is 0, and the batch threshold is one warp (WARP = 32 descriptors).
- R2: A push is accepted exactly when `push_valid` is 1 and fewer than DEPTH (1028) descriptors are queued. At DEPTH the push is refused with `push_ready` = 0, and no queued descriptor is overwritten.
- R3: Descriptors are handed out in push order. `issue_base` is the slot of the oldest queued descriptor. Slot numbers run from 0 to DEPTH-1 and wrap back to 0, with DEPTH not a power of two. `rd_data` returns the descriptor stored at `rd_addr` in the same cycle.
- R4: When `core_free` is 1 and at least threshold×WARP descriptors are queued, `issue_valid` pulses in the next cycle with `issue_count` = threshold×WARP.
- R5: When `core_free` is 1, the queue is non-empty but below threshold×WARP, and the wait timer is at least `timeout_cfg`, `issue_valid` pulses in the next cycle. `issue_count` then equals the whole queued count.
- R6: No batch is issued in a cycle after one in which `core_free` was 0. After an issue, the queued count drops by `issue_count`.
- R7: The wait timer restarts at 0 on every issue and whenever the queue is empty. Otherwise it advances by one each cycle. As a result, a single descriptor pushed into an empty queue with a free core is issued on the (`timeout_cfg`+1)-th edge after the one that accepted it.
- R8: Accepted pushes are counted over windows of WINDOW (64) cycles. At the end of each window the threshold changes:
  - it halves, but not below one warp, when the window saw at most SPARSE_LIM (4) pushes;
  - it doubles, but not above MAX_WARPS (4) warps, when the window saw at least DENSE_LIM (32) pushes.
  
  The new threshold applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Host offers a descriptor |
| push_data | input | 32 | Descriptor or pointer |
| push_ready | output | 1 | Queue can accept a descriptor this cycle |
| core_free | input | 1 | A core slot can take a batch |
| timeout_cfg | input | 16 | Wait limit in cycles before a partial batch |
| issue_valid | output | 1 | One-cycle batch hand-off strobe |
| issue_base | output | 11 | Queue slot of the first descriptor in the batch |
| issue_count | output | 11 | Number of descriptors in the batch |
| rd_addr | input | 11 | Slot the cores read |
| rd_data | output | 32 | Descriptor stored at `rd_addr` |

## Verification
A wrong internal state shows up at the ports in different ways.

- **Queued count.** A corrupted count shows up as a `push_ready` that drops too early or too late near 1028 entries. It also shows up as an `issue_count` that disagrees with the pushes not yet issued, at the very next hand-off.
- **Head or tail slot.** A wrong head or tail slot shows up as an `issue_base` off the expected slot. It also shows up as `rd_data` at the first or last slot of a batch that does not hold the expected descriptor. This is visible in the cycle the batch appears, including batches that straddle the wrap from slot 1027 to slot 0.
- **Threshold or wait timer.** A wrong threshold or wait timer shifts the size or the cycle of the next hand-off, which a cycle-by-cycle reference model exposes at once.

// File: rtl/wbd_pkg.sv
// Shared helpers for the batch dispatcher.
// Assumes every index passed in is already below the ring depth.
package wbd_pkg;

    // Advance a ring index by inc slots, wrapping at depth (any depth, not only 2^n).
    function automatic int unsigned ring_add(int unsigned idx, int unsigned inc, int unsigned depth);
        int unsigned s;
        s = idx + inc;
        return (s >= depth) ? s - depth : s;
    endfunction

endpackage

// File: rtl/desc_ring.sv
// Descriptor storage: a circular buffer of DEPTH words with one write pointer.
// Assumes the caller only asserts wr_en when the ring has a free slot.
// The read port is combinational so cores can fetch by slot number.
module desc_ring #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 1028,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  tail_q;

    // Store an accepted descriptor at the tail slot.
    always_ff @(posedge clk) begin
        if (wr_en) mem[tail_q] <= wr_data;
    end

    // Move the tail forward one slot per accepted push, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n)     tail_q <= '0;
        else if (wr_en) tail_q <= IDX_W'(wbd_pkg::ring_add(int'(tail_q), 1, DEPTH));
    end

    // Fetch the descriptor the cores ask for.
    assign rd_data = mem[rd_addr];

    assert_tail_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tail_q) < DEPTH);
endmodule

// File: rtl/rate_tracker.sv
// Arrival-rate estimator and batch threshold, kept in warps.
// Counts accepted pushes per WINDOW-cycle window. At the end of a window it
// halves the threshold after sparse traffic and doubles it after dense traffic.
// Assumes MAX_WARPS is a power of two so halving and doubling stay on legal values.
module rate_tracker #(
    parameter int WINDOW     = 64,
    parameter int SPARSE_LIM = 4,
    parameter int DENSE_LIM  = 32,
    parameter int MAX_WARPS  = 4,
    localparam int WIN_W = $clog2(WINDOW),
    localparam int ARR_W = $clog2(WINDOW + 1),
    localparam int THR_W = $clog2(MAX_WARPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arrival,
    output logic [THR_W-1:0] thr_warps
);
    logic [WIN_W-1:0] win_q;
    logic [ARR_W-1:0] arr_q;
    logic [ARR_W-1:0] arr_total;
    logic [THR_W-1:0] thr_q;
    logic             win_last;

    assign win_last  = (int'(win_q) == WINDOW - 1);
    assign arr_total = arr_q + ARR_W'(arrival);

    // Step the window position and the arrival count inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
            arr_q <= '0;
        end else if (win_last) begin
            win_q <= '0;
            arr_q <= '0;
        end else begin
            win_q <= win_q + 1'b1;
            arr_q <= arr_total;
        end
    end

    // Adapt the threshold once per window, clamped to [1, MAX_WARPS].
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= THR_W'(1);
        end else if (win_last) begin
            if (int'(arr_total) <= SPARSE_LIM) begin
                if (thr_q > THR_W'(1)) thr_q <= thr_q >> 1;
            end else if (int'(arr_total) >= DENSE_LIM) begin
                if (int'(thr_q) * 2 <= MAX_WARPS) thr_q <= thr_q << 1;
            end
        end
    end

    assign thr_warps = thr_q;

    assert_thr_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(thr_q) == 1 && int'(thr_q) <= MAX_WARPS);
    assert_thr_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !win_last |=> $stable(thr_q));
endmodule

// File: rtl/issue_sched.sv
// Batch issue decision. Tracks the queued count, the head slot and the wait timer.
// Fires a full batch when the queue holds a threshold's worth of descriptors.
// Fires a partial batch when the wait timer reaches timeout_cfg.
// Both kinds of batch need a free core.
// Assumes push_acc is only raised while the count is below DEPTH.
module issue_sched #(
    parameter int DEPTH     = 1028,
    parameter int WARP      = 32,
    parameter int MAX_WARPS = 4,
    parameter int TO_W      = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int THR_W = $clog2(MAX_WARPS + 1),
    localparam int BATCH_MAX = MAX_WARPS * WARP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_acc,
    input  logic             core_free,
    input  logic [TO_W-1:0]  timeout_cfg,
    input  logic [THR_W-1:0] thr_warps,
    output logic [CNT_W-1:0] occupancy,
    output logic             issue_valid,
    output logic [IDX_W-1:0] issue_base,
    output logic [CNT_W-1:0] issue_count
);
    logic [CNT_W-1:0] count_q;
    logic [IDX_W-1:0] head_q;
    logic [TO_W-1:0]  age_q;
    logic [CNT_W-1:0] thr_pkts;
    logic             full_go;
    logic             late_go;
    logic             fire;
    logic [CNT_W-1:0] take;
    logic             iv_q;
    logic [IDX_W-1:0] base_q;
    logic [CNT_W-1:0] cnt_q;

    // Decide whether a full or a timed-out partial batch leaves this cycle.
    always_comb begin
        thr_pkts = CNT_W'(int'(thr_warps) * WARP);
        full_go  = core_free && (count_q >= thr_pkts);
        late_go  = core_free && !full_go && (count_q != '0) && (age_q >= timeout_cfg);
        fire     = full_go || late_go;
        take     = full_go ? thr_pkts : (late_go ? count_q : '0);
    end

    // Update the queued count and the head slot for pushes and issues.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            head_q  <= '0;
        end else begin
            count_q <= count_q + CNT_W'(push_acc) - take;
            head_q  <= IDX_W'(wbd_pkg::ring_add(int'(head_q), int'(take), DEPTH));
        end
    end

    // Wait timer: cleared on issue or when empty, else counts up with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)                  age_q <= '0;
        else if (fire)               age_q <= '0;
        else if (count_q == '0)      age_q <= '0;
        else if (age_q != '1)        age_q <= age_q + 1'b1;
    end

    // Register the batch hand-off toward the cores.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iv_q   <= 1'b0;
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            iv_q <= fire;
            if (fire) begin
                base_q <= head_q;
                cnt_q  <= take;
            end
        end
    end

    assign occupancy   = count_q;
    assign issue_valid = iv_q;
    assign issue_base  = base_q;
    assign issue_count = cnt_q;

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count_q) <= DEPTH);
    assert_no_push_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(count_q) == DEPTH) |-> !push_acc);
    assert_issue_needs_core_R6: assert property (@(posedge clk) disable iff (!rst_n)
        iv_q |-> $past(core_free));
    assert_issue_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
        iv_q |-> (cnt_q != '0 && int'(cnt_q) <= BATCH_MAX));
    assert_base_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(head_q) < DEPTH);
endmodule

// File: rtl/warp_batch_dispatcher.sv
// Top of the adaptive batch dispatcher. Combines the descriptor ring, the rate
// tracker and the issue scheduler. Push acceptance is decided here from the
// scheduler's occupancy so the ring is never written while full.
module warp_batch_dispatcher #(
    parameter int DATA_W     = 32,
    parameter int DEPTH      = 1028,
    parameter int WARP       = 32,
    parameter int MAX_WARPS  = 4,
    parameter int WINDOW     = 64,
    parameter int SPARSE_LIM = 4,
    parameter int DENSE_LIM  = 32,
    parameter int TO_W       = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int THR_W = $clog2(MAX_WARPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_ready,
    input  logic              core_free,
    input  logic [TO_W-1:0]   timeout_cfg,
    output logic              issue_valid,
    output logic [IDX_W-1:0]  issue_base,
    output logic [CNT_W-1:0]  issue_count,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [CNT_W-1:0] occupancy;
    logic [THR_W-1:0] thr_warps;
    logic             push_acc;

    // Accept a push only while a slot is free.
    assign push_ready = (int'(occupancy) < DEPTH);
    assign push_acc   = push_valid && push_ready;

    desc_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push_acc),
        .wr_data (push_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    rate_tracker #(.WINDOW(WINDOW), .SPARSE_LIM(SPARSE_LIM), .DENSE_LIM(DENSE_LIM),
                   .MAX_WARPS(MAX_WARPS)) u_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .arrival   (push_acc),
        .thr_warps (thr_warps)
    );

    issue_sched #(.DEPTH(DEPTH), .WARP(WARP), .MAX_WARPS(MAX_WARPS), .TO_W(TO_W)) u_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_acc    (push_acc),
        .core_free   (core_free),
        .timeout_cfg (timeout_cfg),
        .thr_warps   (thr_warps),
        .occupancy   (occupancy),
        .issue_valid (issue_valid),
        .issue_base  (issue_base),
        .issue_count (issue_count)
    );

    assert_ready_when_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == '0) |-> push_ready);
endmodule

// File: tb/tb_warp_batch_dispatcher.sv
// Self-checking bench: a cycle-level reference model built from the requirements,
// driven by directed corner cases and seeded random traffic.
module tb_warp_batch_dispatcher;
    localparam int DEPTH = 1028, WARP = 32, MAXW = 4, WINDOW = 64, SPARSE = 4, DENSE = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic [31:0] push_data = '0;
    logic        push_ready;
    logic        core_free = 1'b0;
    logic [15:0] timeout_cfg = 16'd10;
    logic        issue_valid;
    logic [10:0] issue_base;
    logic [10:0] issue_count;
    logic [10:0] rd_addr = '0;
    logic [31:0] rd_data;

    int checks = 0, fails = 0;
    bit done = 0;

    // Reference model state
    logic [31:0] mdata [DEPTH];
    int m_count, m_head, m_tail, m_age, m_thr, m_win, m_arr, m_base, m_cnt;
    bit m_iv;

    always #5 clk = ~clk;

    warp_batch_dispatcher dut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
        .push_ready(push_ready), .core_free(core_free), .timeout_cfg(timeout_cfg),
        .issue_valid(issue_valid), .issue_base(issue_base), .issue_count(issue_count),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic int wrap(int idx, int inc);
        int s = idx + inc;
        return (s >= DEPTH) ? s - DEPTH : s;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_count = 0; m_head = 0; m_tail = 0; m_age = 0; m_thr = 1;
        m_win = 0; m_arr = 0; m_iv = 0; m_base = 0; m_cnt = 0;
    endtask

    // Next model state from the inputs about to be sampled.
    task automatic model_step(input bit pv, input logic [31:0] pd, input bit cf);
        bit acc, full, late;
        int thrp, n, tot, c0;
        c0   = m_count;
        acc  = pv && (c0 < DEPTH);
        thrp = m_thr * WARP;
        full = cf && (c0 >= thrp);
        late = cf && !full && (c0 != 0) && (m_age >= int'(timeout_cfg));
        n    = full ? thrp : (late ? c0 : 0);
        if (acc) begin
            mdata[m_tail] = pd;
            m_tail = wrap(m_tail, 1);
        end
        m_iv = full || late;
        if (m_iv) begin
            m_base = m_head;
            m_cnt  = n;
        end
        m_head = wrap(m_head, n);
        if (m_iv || c0 == 0) m_age = 0;
        else if (m_age < 65535) m_age++;
        m_count = c0 + int'(acc) - n;
        tot = m_arr + int'(acc);
        if (m_win == WINDOW - 1) begin
            if (tot <= SPARSE) begin
                if (m_thr > 1) m_thr = m_thr / 2;
            end else if (tot >= DENSE) begin
                if (m_thr * 2 <= MAXW) m_thr = m_thr * 2;
            end
            m_arr = 0; m_win = 0;
        end else begin
            m_arr = tot; m_win++;
        end
    endtask

    // One clock: drive, advance model, then compare just after the edge.
    task automatic step(input bit pv, input logic [31:0] pd, input bit cf);
        push_valid = pv; push_data = pd; core_free = cf;
        model_step(pv, pd, cf);
        @(posedge clk); #1;
        chk(push_ready == (m_count < DEPTH), "R2 push_ready", push_ready, m_count < DEPTH);
        chk(issue_valid == m_iv, "R4/R5/R6 issue_valid", issue_valid, m_iv);
        if (m_iv && issue_valid) begin
            chk(int'(issue_count) == m_cnt, "R4/R5 issue_count", issue_count, m_cnt);
            chk(int'(issue_base) == m_base, "R3 issue_base", issue_base, m_base);
            rd_addr = 11'(m_base); #1;
            chk(rd_data == mdata[m_base], "R3 first descriptor", rd_data, mdata[m_base]);
            rd_addr = 11'(wrap(m_base, m_cnt - 1)); #1;
            chk(rd_data == mdata[wrap(m_base, m_cnt - 1)], "R3 last descriptor",
                rd_data, mdata[wrap(m_base, m_cnt - 1)]);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int seq;
        int waited;
        int first_cnt;
        bit seen;
        void'($urandom(32'h5EED1234));
        seq = 1;
        model_reset();
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        chk(push_ready == 1'b1, "R1 push_ready after reset", push_ready, 1);
        chk(issue_valid == 1'b0, "R1 issue_valid after reset", issue_valid, 0);

        // R7/R5: lone descriptor, timeout 10, issued on the 11th edge
        timeout_cfg = 16'd10;
        step(1, 32'hA000_0000 + seq++, 1);
        waited = 0; seen = 0;
        for (int i = 0; i < 40 && !seen; i++) begin
            step(0, 0, 1);
            waited++;
            if (issue_valid) begin
                seen = 1;
                chk(waited == 11, "R7 timeout latency", waited, 11);
                chk(issue_count == 11'd1, "R5 partial count", issue_count, 1);
            end
        end
        chk(seen, "R5 partial batch issued", seen, 1);

        // R4/R6: burst of 40 with cores busy, then released
        for (int i = 0; i < 40; i++) step(1, 32'hB000_0000 + seq++, 0);
        for (int i = 0; i < 5; i++) begin
            step(0, 0, 0);
            chk(issue_valid == 1'b0, "R6 no issue while busy", issue_valid, 0);
        end
        step(0, 0, 1);
        chk(issue_valid && issue_count == 11'd32, "R4 full warp", issue_count, 32);
        for (int i = 0; i < 30; i++) step(0, 0, 1);

        // R2/R8: fill to depth with cores busy; dense windows grow the threshold
        for (int i = 0; i < DEPTH + 6; i++) step(1, 32'hC000_0000 + seq++, 0);
        chk(push_ready == 1'b0, "R2 refused when full", push_ready, 0);
        step(0, 0, 1);
        first_cnt = int'(issue_count);
        chk(first_cnt == MAXW * WARP, "R8 threshold grew to max", first_cnt, MAXW * WARP);
        for (int i = 0; i < 600; i++) step(0, 0, 1);

        // R8: after sparse windows the threshold is back to one warp
        for (int i = 0; i < 3 * WINDOW; i++) step(0, 0, 0);
        for (int i = 0; i < WARP; i++) step(1, 32'hD000_0000 + seq++, 0);
        step(0, 0, 1);
        chk(issue_valid && issue_count == 11'(WARP), "R8 threshold shrank", issue_count, WARP);

        // Seeded random traffic in phases (R2-R8 via the model)
        for (int ph = 0; ph < 10; ph++) begin
            int pp, cp;
            pp = (ph % 4 == 0) ? 3 : (ph % 4 == 1) ? 15 : (ph % 4 == 2) ? 60 : 95;
            cp = 20 + int'($urandom_range(0, 70));
            timeout_cfg = 16'($urandom_range(0, 40));
            for (int i = 0; i < 500; i++)
                step(int'($urandom_range(0, 99)) < pp, $urandom, int'($urandom_range(0, 99)) < cp);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule